// File: doc/BRIEF.md
# Stack Machine Next-Address Sequencer

This block is the program-flow engine of a 16-bit stack processor with fixed instruction formats. Each cycle it looks at the instruction word fetched from the current address. It decides the next fetch address from that word: subroutine calls, paged branches, countdown loops, folded returns, or plain sequential flow. Data path work and the data stack sit outside the block. The only data-path fact it needs is whether the top of the data stack is zero, and that arrives on an input.

The block also owns the return stack. The most recent entry lives in a register called the Index, which is visible on the ports so that the data path can read it. Older entries spill into a return stack memory inside the block, which has 256 entries by default. There is no overflow or underflow protection, so the pointer simply wraps.

Two instruction kinds occupy the bus for a second cycle:
- A memory reference uses the second cycle for its operand.
- A long literal uses it to read the word that follows it.

In both cases the sequencer raises `stall` for that second cycle and ignores the word on `instr`.

Top module: `nextaddr_seq`

## Requirements
- R1: While reset is held, and right after it, `fetchAddr` is 0, `stall` is 0, `indexTop` is 0 and the return stack is empty.
- R2: An instruction that does not alter flow and is not a two-cycle kind makes `fetchAddr` advance by one word on the next cycle. Such instructions are an ALU word without the return bit (bits 15:12 = 1100), or a short miscellaneous word (bits 15:12 = 1110).
- R3: A word with bit 15 = 0 is a call. On the next cycle `fetchAddr` = {0, instr[14:0]} and `indexTop` = old `fetchAddr` + 1, and the old Index is pushed into the return stack memory.
- R4: An ALU word (bits 15:12 = 1100) with bit 5 = 1 is a return. On the next cycle `fetchAddr` = old `indexTop`, and `indexTop` takes the most recently pushed entry. Nested calls therefore unwind in last-in, first-out order.
- R5: A branch word has bits 15:14 = 10. When the branch is taken, the target keeps bits 15:12 of the current address and takes bits 11:0 from the instruction.
- R6: Branch mode bits 13:12 = 00 is taken only when `tIsZero` is 1; otherwise flow advances by one.
- R7: Branch mode 01 is always taken.
- R8: Branch mode 10 is the loop mode. When `indexTop` is non-zero it is decremented and the branch is taken. When it is zero, flow advances by one and `indexTop` stays at 0.
- R9: Branch mode 11 never branches and leaves `indexTop` unchanged.
- R10: A memory reference (bits 15:12 = 1101) moves `fetchAddr` to the next word with `stall` = 1. During that stall cycle the address is held and the word on `instr` has no effect on flow, on `stall` or on `indexTop`.
- R11: A long literal (bits 15:12 = 1111) moves `fetchAddr` to the literal word with `stall` = 1. It then moves to the word after the literal, ignoring the literal's value.
- R12: Bit 5 in a non-ALU word (memory reference or short miscellaneous) does not cause a return: `indexTop` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instr | input | 16 | Instruction word read from `fetchAddr` |
| tIsZero | input | 1 | Top of data stack equals zero |
| fetchAddr | output | 16 | Program counter / next fetch word address |
| stall | output | 1 | Second cycle of a two-cycle instruction; `instr` is ignored |
| indexTop | output | 16 | Current top of the return stack (Index register) |

## Verification
The hardest state to reach from the ports is a small, known Index value for the loop mode. Every call loads Index with the return address, so a small count can only come from a call placed near address zero. The stimulus therefore steps from reset to word 2 and calls from there, which leaves Index = 3. It then repeats one loop branch until the count is exhausted, covering both the taken-and-decrement path and the fall-through at zero. A chain of three nested calls followed by three folded returns checks the spill and refill through the return stack memory. The words fed during the stall cycles are deliberately a call and a return, which proves that they are ignored.

// File: rtl/nextaddr_pkg.sv
package nextaddr_pkg;

  localparam int WORD_W    = 16;
  localparam int CALL_W    = 15;
  localparam int PAGE_LO_W = 12;

  // branch mode field (instr[13:12])
  localparam logic [1:0] BR_TZERO  = 2'b00;
  localparam logic [1:0] BR_ALWAYS = 2'b01;
  localparam logic [1:0] BR_LOOP   = 2'b10;

  // sub-format field of the 11xx group (instr[13:12])
  localparam logic [1:0] SUB_ALU  = 2'b00;
  localparam logic [1:0] SUB_MEM  = 2'b01;
  localparam logic [1:0] SUB_LIT  = 2'b11;

  typedef enum logic [2:0] {
    PC_INC,
    PC_HOLD,
    PC_CALL,
    PC_BRANCH,
    PC_RET
  } pcSel_e;

  typedef enum logic [1:0] {
    PH_RUN,
    PH_MEM,
    PH_LIT
  } phase_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   pushRs;
    logic   popRs;
    logic   decIndex;
  } seqStrobes_t;

endpackage

// File: rtl/nextaddr_ctrl.sv
module nextaddr_ctrl
  import nextaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  fmtBits,
  input  logic        retBit,
  input  logic        tIsZero,
  input  logic        indexZero,
  output seqStrobes_t strobes,
  output logic        stall
);

  phase_e phase, phaseNext;

  always_comb begin
    strobes   = '{pcSel: PC_INC, pushRs: 1'b0, popRs: 1'b0, decIndex: 1'b0};
    phaseNext = PH_RUN;
    unique case (phase)
      PH_MEM: strobes.pcSel = PC_HOLD;
      PH_LIT: strobes.pcSel = PC_INC;
      default: begin
        if (!fmtBits[3]) begin
          strobes.pcSel  = PC_CALL;
          strobes.pushRs = 1'b1;
        end else if (!fmtBits[2]) begin
          unique case (fmtBits[1:0])
            BR_TZERO:  if (tIsZero) strobes.pcSel = PC_BRANCH;
            BR_ALWAYS: strobes.pcSel = PC_BRANCH;
            BR_LOOP: begin
              if (!indexZero) begin
                strobes.pcSel    = PC_BRANCH;
                strobes.decIndex = 1'b1;
              end
            end
            default: strobes.pcSel = PC_INC;
          endcase
        end else begin
          unique case (fmtBits[1:0])
            SUB_ALU: begin
              if (retBit) begin
                strobes.pcSel = PC_RET;
                strobes.popRs = 1'b1;
              end
            end
            SUB_MEM: phaseNext = PH_MEM;
            SUB_LIT: phaseNext = PH_LIT;
            default: strobes.pcSel = PC_INC;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_RUN;
    else       phase <= phaseNext;
  end

  assign stall = (phase != PH_RUN);

  p_stall_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  p_mem_enter_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && fmtBits == 4'hD) |=> stall);

  p_lit_enter_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && fmtBits == 4'hF) |=> stall);

  p_one_stack_op_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.pushRs, strobes.popRs, strobes.decIndex}) <= 1);

endmodule

// File: rtl/nextaddr_dp.sv
module nextaddr_dp
  import nextaddr_pkg::*;
#(
  parameter int RS_DEPTH = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CALL_W-1:0]   addrField,
  input  seqStrobes_t         strobes,
  output logic [WORD_W-1:0]   pc,
  output logic [WORD_W-1:0]   index,
  output logic                indexZero
);

  localparam int RSP_W   = (RS_DEPTH > 1) ? $clog2(RS_DEPTH) : 1;
  localparam int PAGE_HI = WORD_W - PAGE_LO_W;

  logic [WORD_W-1:0] rsMem [RS_DEPTH];
  logic [RSP_W-1:0]  rsPtr;
  logic [RSP_W-1:0]  rsTopAddr;
  logic [WORD_W-1:0] pcInc;
  logic [WORD_W-1:0] pcNext;
  logic [WORD_W-1:0] indexNext;
  logic [WORD_W-1:0] callTarget;
  logic [WORD_W-1:0] branchTarget;

  assign pcInc        = pc + WORD_W'(1);
  assign callTarget   = {{(WORD_W-CALL_W){1'b0}}, addrField};
  assign branchTarget = {pc[WORD_W-1 -: PAGE_HI], addrField[PAGE_LO_W-1:0]};
  assign rsTopAddr    = rsPtr - RSP_W'(1);
  assign indexZero    = (index == '0);

  always_comb begin
    unique case (strobes.pcSel)
      PC_HOLD:   pcNext = pc;
      PC_CALL:   pcNext = callTarget;
      PC_BRANCH: pcNext = branchTarget;
      PC_RET:    pcNext = index;
      default:   pcNext = pcInc;
    endcase
  end

  always_comb begin
    indexNext = index;
    if (strobes.pushRs)        indexNext = pcInc;
    else if (strobes.popRs)    indexNext = rsMem[rsTopAddr];
    else if (strobes.decIndex) indexNext = index - WORD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= '0;
      index <= '0;
      rsPtr <= '0;
    end else begin
      pc    <= pcNext;
      index <= indexNext;
      if (strobes.pushRs)     rsPtr <= rsPtr + RSP_W'(1);
      else if (strobes.popRs) rsPtr <= rsTopAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.pushRs) rsMem[rsPtr] <= index;
  end

  p_push_ptr_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushRs |=> rsPtr == RSP_W'($past(rsPtr) + RSP_W'(1)));

  p_pop_ptr_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popRs |=> rsPtr == RSP_W'($past(rsPtr) - RSP_W'(1)));

  p_idle_ptr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.pushRs && !strobes.popRs) |=> $stable(rsPtr));

endmodule

// File: rtl/nextaddr_seq.sv
module nextaddr_seq
  import nextaddr_pkg::*;
#(
  parameter int RS_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       instr,
  input  logic              tIsZero,
  output logic [15:0]       fetchAddr,
  output logic              stall,
  output logic [15:0]       indexTop
);

  seqStrobes_t strobes;
  logic        indexZero;

  nextaddr_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fmtBits   (instr[15:12]),
    .retBit    (instr[5]),
    .tIsZero   (tIsZero),
    .indexZero (indexZero),
    .strobes   (strobes),
    .stall     (stall)
  );

  nextaddr_dp #(.RS_DEPTH(RS_DEPTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .addrField (instr[CALL_W-1:0]),
    .strobes   (strobes),
    .pc        (fetchAddr),
    .index     (indexTop),
    .indexZero (indexZero)
  );

  p_call_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !instr[15]) |=> fetchAddr == {1'b0, $past(instr[14:0])});

  p_call_link_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !instr[15]) |=> indexTop == $past(fetchAddr) + 16'd1);

  p_ret_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && instr[15:12] == 4'hC && instr[5]) |=> fetchAddr == $past(indexTop));

  p_branch_page_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && instr[15:12] == 4'h9)
      |=> fetchAddr == {$past(fetchAddr[15:12]), $past(instr[11:0])});

  p_loop_dec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && instr[15:12] == 4'hA && indexTop != 16'd0)
      |=> indexTop == $past(indexTop) - 16'd1);

  p_loop_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && instr[15:12] == 4'hA && indexTop == 16'd0)
      |=> fetchAddr == $past(fetchAddr) + 16'd1);

  p_no_branch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && instr[15:12] == 4'hB) |=> $stable(indexTop));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(instr[15:12]) == 4'hD && !$past(stall)) |=> $stable(fetchAddr));

endmodule

// File: tb/test_nextaddr_seq.sv
`timescale 1ns/1ps
module test_nextaddr_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] instr;
  logic        tIsZero;
  logic [15:0] fetchAddr;
  logic        stall;
  logic [15:0] indexTop;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] qPc[$];
  logic        qStall[$];
  logic [15:0] qIdx[$];
  string       qTag[$];

  logic [15:0] mPc, mIdx;
  logic [15:0] mStack[$];
  int          mPhase;

  always #2.5 clk = ~clk;

  nextaddr_seq i_nextaddr_seq (
    .clk       (clk),
    .rstN      (rstN),
    .instr     (instr),
    .tIsZero   (tIsZero),
    .fetchAddr (fetchAddr),
    .stall     (stall),
    .indexTop  (indexTop)
  );

  task automatic step(input logic [15:0] ins, input logic tz, input string tag);
    logic [15:0] nPc, nIdx, tgt;
    logic        nStall;
    nPc    = mPc + 16'd1;
    nIdx   = mIdx;
    nStall = 1'b0;
    tgt    = {mPc[15:12], ins[11:0]};
    if (mPhase == 1) begin
      nPc = mPc; mPhase = 0;
    end else if (mPhase == 2) begin
      mPhase = 0;
    end else if (!ins[15]) begin
      mStack.push_back(mIdx);
      nIdx = mPc + 16'd1;
      nPc  = {1'b0, ins[14:0]};
    end else if (!ins[14]) begin
      case (ins[13:12])
        2'b00: if (tz) nPc = tgt;
        2'b01: nPc = tgt;
        2'b10: if (mIdx != 16'd0) begin nIdx = mIdx - 16'd1; nPc = tgt; end
        default: ;
      endcase
    end else begin
      case (ins[13:12])
        2'b00: if (ins[5]) begin nPc = mIdx; nIdx = mStack.pop_back(); end
        2'b01: begin nStall = 1'b1; mPhase = 1; end
        2'b11: begin nStall = 1'b1; mPhase = 2; end
        default: ;
      endcase
    end
    instr   = ins;
    tIsZero = tz;
    qPc.push_back(nPc);
    qStall.push_back(nStall);
    qIdx.push_back(nIdx);
    qTag.push_back(tag);
    mPc  = nPc;
    mIdx = nIdx;
    @(negedge clk);
  endtask

  // monitor: compares each result one step after its edge
  always @(posedge clk) begin
    #1;
    if (qPc.size() > 0) begin
      logic [15:0] ePc, eIdx;
      logic        eSt;
      string       t;
      ePc = qPc.pop_front();
      eSt = qStall.pop_front();
      eIdx = qIdx.pop_front();
      t = qTag.pop_front();
      checks++;
      if (fetchAddr !== ePc || stall !== eSt || indexTop !== eIdx) begin
        errors++;
        $display("FAIL %s: addr/stall/index got %h/%b/%h expected %h/%b/%h",
                 t, fetchAddr, stall, indexTop, ePc, eSt, eIdx);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; instr = 16'hE000; tIsZero = 1'b0;
    mPc = 16'd0; mIdx = 16'd0; mPhase = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (fetchAddr !== 16'd0 || stall !== 1'b0 || indexTop !== 16'd0) begin
      errors++;
      $display("FAIL R1: reset addr/stall/index got %h/%b/%h expected 0000/0/0000",
               fetchAddr, stall, indexTop);
    end
    rstN = 1'b1;
    step(16'hE000, 1'b0, "R2 short misc advances");
    step(16'hC000, 1'b0, "R2 ALU without return advances");
    // call from word 2 gives a small loop count in Index
    step(16'h7F00, 1'b0, "R3 call loads link");
    step(16'hAF00, 1'b0, "R8 loop taken count 3");
    step(16'hAF00, 1'b0, "R8 loop taken count 2");
    step(16'hAF00, 1'b0, "R8 loop taken count 1");
    step(16'hAF00, 1'b0, "R8 loop falls through at zero");
    step(16'hB555, 1'b1, "R9 mode 11 no branch");
    step(16'h9123, 1'b0, "R7 unconditional keeps page (R5)");
    step(16'h8200, 1'b0, "R6 tzero not taken");
    step(16'h8200, 1'b1, "R6 tzero taken, page kept (R5)");
    step(16'hC020, 1'b0, "R4 return to link");
    // nested calls spill into return stack memory
    step(16'h0100, 1'b0, "R3 nested call 1");
    step(16'h0200, 1'b0, "R3 nested call 2");
    step(16'h0300, 1'b0, "R3 nested call 3");
    step(16'hE020, 1'b0, "R12 misc with bit 5 no return");
    step(16'hC020, 1'b0, "R4 unwind 3");
    step(16'hC020, 1'b0, "R4 unwind 2");
    step(16'hD020, 1'b0, "R10 memref enters stall (R12)");
    step(16'h0000, 1'b0, "R10 call word ignored in stall");
    step(16'hF000, 1'b0, "R11 long literal enters stall");
    step(16'hC020, 1'b0, "R11 return word ignored in literal slot");
    step(16'hC020, 1'b0, "R4 unwind 1");
    step(16'h7FFF, 1'b0, "R3 call to top of space");
    step(16'hE000, 1'b0, "R2 advance past 7FFF");
    step(16'hC020, 1'b0, "R4 final return");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule